// File: doc/BRIEF.md
# MMU Control Coprocessor Register File

This block is the register side of a small memory management unit. The processor reaches it with coprocessor register-transfer instructions. The block decodes each instruction and then either returns the contents of a register or updates one. A write stores the data after a fixed mask is applied. The identity register returns a configured value. Writes to the maintenance registers do not store anything. Instead they become one-cycle invalidate commands for a cache and a translation look-aside buffer. The cache and the TLB sit outside this block.

The input `mode_new` selects one of two register maps. In the newer map, the fault registers can be written and read back. Maintenance requests go through a cache-operation register and a TLB-operation register, and the instruction's opcode field (bits [7:5]) selects the operation. In the older map, three fixed flush registers replace these: flush the whole TLB, flush one TLB entry, and flush the cache. In that map the fault registers are neither written nor readable.

The command generator is a small state machine. It has four states:

- IDLE: no command is issued.
- INV_CACHE: the cache invalidate-all pulse is high.
- INV_TLB_ALL: the TLB invalidate-all pulse is high.
- INV_TLB_ONE: the TLB invalidate-entry pulse is high and its address is valid.

Every clock edge leads from any state into the state that the accepted maintenance write names, or back to IDLE when there is none.

Top module: `mmu_cp_regs`

## Requirements
- R1: The register number is taken from instruction bits [19:16]. The numbers are 0 identity, 1 control, 2 table base, 3 domain access, 5 fault status, 6 fault address, 7 cache operations and 8 TLB operations. In the older map, 5, 6 and 7 are flush-TLB, flush-entry and flush-cache. A write is stored at the clock edge where `acc_valid` and `acc_write` are both high.
- R2: A control write stores (data OR 0x70) AND 0xFFFF.
- R3: A table-base write stores the data with bits [13:0] cleared.
- R4: A domain write stores all 32 bits.
- R5: In the newer map, a fault-status write keeps data bits [7:0] and a fault-address write keeps all 32 bits.
- R6: In the newer map, a write to register 7 with bits [7:5] equal to 0 raises `cache_inv_all` for one cycle after the edge. Any other opcode value raises nothing.
- R7: In the newer map, a write to register 8 with opcode 0 raises `tlb_inv_all`. Opcode 1 raises `tlb_inv_entry`, with `tlb_inv_addr` equal to the write data. Other opcodes raise nothing.
- R8: In the older map, writes to 5, 6 and 7 raise `tlb_inv_all`, `tlb_inv_entry` (address from the data) and `cache_inv_all` whatever the opcode. The stored fault registers never change in this map.
- R9: While a read is strobed, `rdata` returns the addressed register combinationally. Register 0 returns `cfg_id`. Undefined registers, including the maintenance registers and the fault registers in the older map, return 0. With no read strobed, `rdata` is 0.
- R10: After reset, control holds 0x0070, every other register holds 0 and no pulse is high.
- R11: Writes to undefined registers and all reads leave every register and pulse unchanged.
- R12: Each pulse lasts one cycle per accepted write, and at most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_new | input | 1 | 1 selects the newer register map, 0 the older one |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| instr | input | 32 | Register-transfer instruction word |
| wdata | input | 32 | Write data |
| cfg_id | input | 32 | Value returned by the identity register |
| rdata | output | 32 | Read data |
| ctrl_q | output | 32 | Current control register |
| ttb_q | output | 32 | Current translation table base |
| dom_q | output | 32 | Current domain access control |
| fsr_q | output | 32 | Current fault status, zero-extended |
| far_q | output | 32 | Current fault address |
| cache_inv_all | output | 1 | Cache invalidate-all pulse |
| tlb_inv_all | output | 1 | TLB invalidate-all pulse |
| tlb_inv_entry | output | 1 | TLB invalidate-entry pulse |
| tlb_inv_addr | output | 32 | Virtual address for the entry invalidate |

## Verification
Write data with all ones, with all zeros and with mixed patterns is sent to each storing register. Each pattern is then read back, which separates the forced control bits, the cleared base bits and the truncated fault status from plain storage.

Each maintenance register is driven with every relevant opcode in both maps. This shows that the map, and not only the register number, picks the pulse, and that unused opcodes stay silent.

Further cases cover undefined registers, reads of maintenance registers, back-to-back commands and reads of the fault registers after older-map traffic. These separate real commands from stray ones and show that the older map leaves the fault state untouched.

// File: rtl/mmu_cp_pkg.sv
package mmu_cp_pkg;

    localparam logic [3:0] RN_ID    = 4'd0;
    localparam logic [3:0] RN_CTRL  = 4'd1;
    localparam logic [3:0] RN_TTB   = 4'd2;
    localparam logic [3:0] RN_DOM   = 4'd3;
    localparam logic [3:0] RN_FSR   = 4'd5;
    localparam logic [3:0] RN_FAR   = 4'd6;
    localparam logic [3:0] RN_CACHE = 4'd7;
    localparam logic [3:0] RN_TLB   = 4'd8;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_WR_CTRL,
        OP_WR_TTB,
        OP_WR_DOM,
        OP_WR_FSR,
        OP_WR_FAR,
        OP_INV_CACHE,
        OP_INV_TLB_ALL,
        OP_INV_TLB_ONE
    } cp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INV_CACHE,
        ST_INV_TLB_ALL,
        ST_INV_TLB_ONE
    } maint_st_e;

endpackage

// File: rtl/cp_decode.sv
module cp_decode
    import mmu_cp_pkg::*;
#(
    parameter int INSTR_W    = 32,
    parameter int REGNUM_LSB = 16,
    parameter int OPC_LSB    = 5
) (
    input  logic               mode_new,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [INSTR_W-1:0] instr,
    output cp_op_e             op,
    output logic               rd_en,
    output logic [3:0]         rd_sel
);

    localparam int OPC_W = 3;

    logic [3:0]       regn;
    logic [OPC_W-1:0] opc;

    assign regn   = instr[REGNUM_LSB +: 4];
    assign opc    = instr[OPC_LSB +: OPC_W];
    assign rd_en  = acc_valid && !acc_write;
    assign rd_sel = regn;

    always_comb begin
        op = OP_NONE;
        if (acc_valid && acc_write) begin
            case (regn)
                RN_CTRL: op = OP_WR_CTRL;
                RN_TTB:  op = OP_WR_TTB;
                RN_DOM:  op = OP_WR_DOM;
                RN_FSR:  op = mode_new ? OP_WR_FSR : OP_INV_TLB_ALL;
                RN_FAR:  op = mode_new ? OP_WR_FAR : OP_INV_TLB_ONE;
                RN_CACHE: begin
                    if (!mode_new || opc == '0) op = OP_INV_CACHE;
                end
                RN_TLB: begin
                    if (mode_new) begin
                        if (opc == 3'd0)      op = OP_INV_TLB_ALL;
                        else if (opc == 3'd1) op = OP_INV_TLB_ONE;
                    end
                end
                default: op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cp_regbank.sv
module cp_regbank
    import mmu_cp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CTRL_KEEP  = 16,
    parameter int CTRL_FORCE = 'h70,
    parameter int TTB_ALIGN  = 14,
    parameter int FSR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_new,
    input  cp_op_e            op,
    input  logic              rd_en,
    input  logic [3:0]        rd_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cfg_id,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ttb_q,
    output logic [DATA_W-1:0] dom_q,
    output logic [DATA_W-1:0] fsr_q,
    output logic [DATA_W-1:0] far_q
);

    localparam logic [DATA_W-1:0] CTRL_MASK =
        {{(DATA_W-CTRL_KEEP){1'b0}}, {CTRL_KEEP{1'b1}}};
    localparam logic [DATA_W-1:0] CTRL_SET  = DATA_W'(CTRL_FORCE);
    localparam logic [DATA_W-1:0] TTB_MASK  =
        {{(DATA_W-TTB_ALIGN){1'b1}}, {TTB_ALIGN{1'b0}}};

    logic [FSR_W-1:0] fsr_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_SET;
            ttb_q  <= '0;
            dom_q  <= '0;
            fsr_r  <= '0;
            far_q  <= '0;
        end else begin
            case (op)
                OP_WR_CTRL: ctrl_q <= (wdata | CTRL_SET) & CTRL_MASK;
                OP_WR_TTB:  ttb_q  <= wdata & TTB_MASK;
                OP_WR_DOM:  dom_q  <= wdata;
                OP_WR_FSR:  fsr_r  <= wdata[FSR_W-1:0];
                OP_WR_FAR:  far_q  <= wdata;
                default: ;
            endcase
        end
    end

    assign fsr_q = {{(DATA_W-FSR_W){1'b0}}, fsr_r};

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (rd_sel)
                RN_ID:   rdata = cfg_id;
                RN_CTRL: rdata = ctrl_q;
                RN_TTB:  rdata = ttb_q;
                RN_DOM:  rdata = dom_q;
                RN_FSR:  rdata = mode_new ? fsr_q : '0;
                RN_FAR:  rdata = mode_new ? far_q : '0;
                default: rdata = '0;
            endcase
        end
    end

    // R2
    ctrl_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_q & CTRL_SET) == CTRL_SET) && ((ctrl_q & ~CTRL_MASK) == '0));

    // R3
    ttb_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ttb_q & ~TTB_MASK) == '0);

    // R8
    old_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_new |=> ($stable(fsr_q) && $stable(far_q)));

    // R11
    read_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ($stable(ctrl_q) && $stable(ttb_q) && $stable(dom_q)));

endmodule

// File: rtl/cp_maint.sv
module cp_maint
    import mmu_cp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cp_op_e            op,
    input  logic [DATA_W-1:0] wdata,
    output logic              cache_inv_all,
    output logic              tlb_inv_all,
    output logic              tlb_inv_entry,
    output logic [DATA_W-1:0] tlb_inv_addr
);

    maint_st_e state_q, state_d;

    always_comb begin
        unique case (op)
            OP_INV_CACHE:   state_d = ST_INV_CACHE;
            OP_INV_TLB_ALL: state_d = ST_INV_TLB_ALL;
            OP_INV_TLB_ONE: state_d = ST_INV_TLB_ONE;
            default:        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            tlb_inv_addr <= '0;
        end else begin
            state_q <= state_d;
            if (op == OP_INV_TLB_ONE) tlb_inv_addr <= wdata;
        end
    end

    always_comb begin
        cache_inv_all = 1'b0;
        tlb_inv_all   = 1'b0;
        tlb_inv_entry = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_INV_CACHE:   cache_inv_all = 1'b1;
            ST_INV_TLB_ALL: tlb_inv_all   = 1'b1;
            ST_INV_TLB_ONE: tlb_inv_entry = 1'b1;
            default:        ;
        endcase
    end

    // R12
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cache_inv_all, tlb_inv_all, tlb_inv_entry}));

    // R12
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_inv_all || tlb_inv_all || tlb_inv_entry) |-> $past(op != OP_NONE));

    // R7
    entry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inv_entry |-> (tlb_inv_addr == $past(wdata)));

endmodule

// File: rtl/mmu_cp_regs.sv
module mmu_cp_regs
    import mmu_cp_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int REGNUM_LSB = 16,
    parameter int OPC_LSB    = 5,
    parameter int CTRL_KEEP  = 16,
    parameter int CTRL_FORCE = 'h70,
    parameter int TTB_ALIGN  = 14,
    parameter int FSR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_new,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] instr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cfg_id,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] ttb_q,
    output logic [DATA_W-1:0] dom_q,
    output logic [DATA_W-1:0] fsr_q,
    output logic [DATA_W-1:0] far_q,
    output logic              cache_inv_all,
    output logic              tlb_inv_all,
    output logic              tlb_inv_entry,
    output logic [DATA_W-1:0] tlb_inv_addr
);

    cp_op_e     op;
    logic       rd_en;
    logic [3:0] rd_sel;

    cp_decode #(
        .INSTR_W   (DATA_W),
        .REGNUM_LSB(REGNUM_LSB),
        .OPC_LSB   (OPC_LSB)
    ) u_dec (
        .mode_new (mode_new),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .instr    (instr),
        .op       (op),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel)
    );

    cp_regbank #(
        .DATA_W    (DATA_W),
        .CTRL_KEEP (CTRL_KEEP),
        .CTRL_FORCE(CTRL_FORCE),
        .TTB_ALIGN (TTB_ALIGN),
        .FSR_W     (FSR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_new(mode_new),
        .op      (op),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel),
        .wdata   (wdata),
        .cfg_id  (cfg_id),
        .rdata   (rdata),
        .ctrl_q  (ctrl_q),
        .ttb_q   (ttb_q),
        .dom_q   (dom_q),
        .fsr_q   (fsr_q),
        .far_q   (far_q)
    );

    cp_maint #(
        .DATA_W(DATA_W)
    ) u_maint (
        .clk          (clk),
        .rst_n        (rst_n),
        .op           (op),
        .wdata        (wdata),
        .cache_inv_all(cache_inv_all),
        .tlb_inv_all  (tlb_inv_all),
        .tlb_inv_entry(tlb_inv_entry),
        .tlb_inv_addr (tlb_inv_addr)
    );

    // R11
    read_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !(cache_inv_all || tlb_inv_all || tlb_inv_entry));

    // R9
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (rdata == '0));

endmodule

// File: tb/sim_mmu_cp_regs.sv
module sim_mmu_cp_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_new = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] cfg_id = 32'h4101_7100;
    logic [31:0] rdata, ctrl_q, ttb_q, dom_q, fsr_q, far_q, tlb_inv_addr;
    logic        cache_inv_all, tlb_inv_all, tlb_inv_entry;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mmu_cp_regs u0 (
        .clk(clk), .rst_n(rst_n), .mode_new(mode_new), .acc_valid(acc_valid),
        .acc_write(acc_write), .instr(instr), .wdata(wdata), .cfg_id(cfg_id),
        .rdata(rdata), .ctrl_q(ctrl_q), .ttb_q(ttb_q), .dom_q(dom_q),
        .fsr_q(fsr_q), .far_q(far_q), .cache_inv_all(cache_inv_all),
        .tlb_inv_all(tlb_inv_all), .tlb_inv_entry(tlb_inv_entry),
        .tlb_inv_addr(tlb_inv_addr)
    );

    // pulse encoding in vectors: {cache_inv_all, tlb_inv_all, tlb_inv_entry}
    typedef struct packed {
        logic        mode;
        logic [3:0]  regn;
        logic [2:0]  opc;
        logic [31:0] data;
        logic [2:0]  pulse;
        logic [31:0] rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd1, 3'd0, 32'hFFFF_0000, 3'b000, 32'h0000_0070}, // R2
        '{1'b1, 4'd1, 3'd0, 32'h1234_5687, 3'b000, 32'h0000_56F7}, // R2
        '{1'b1, 4'd2, 3'd0, 32'hFFFF_FFFF, 3'b000, 32'hFFFF_C000}, // R3
        '{1'b1, 4'd3, 3'd0, 32'hA5A5_5A5A, 3'b000, 32'hA5A5_5A5A}, // R4
        '{1'b1, 4'd5, 3'd0, 32'h1234_5678, 3'b000, 32'h0000_0078}, // R5
        '{1'b1, 4'd6, 3'd0, 32'hDEAD_BEEF, 3'b000, 32'hDEAD_BEEF}, // R5
        '{1'b1, 4'd7, 3'd0, 32'h0000_0000, 3'b100, 32'h0000_0000}, // R6
        '{1'b1, 4'd7, 3'd3, 32'h0000_0000, 3'b000, 32'h0000_0000}, // R6
        '{1'b1, 4'd8, 3'd0, 32'h0000_0000, 3'b010, 32'h0000_0000}, // R7
        '{1'b1, 4'd8, 3'd1, 32'h0040_1000, 3'b001, 32'h0000_0000}, // R7
        '{1'b1, 4'd8, 3'd2, 32'h0000_0000, 3'b000, 32'h0000_0000}, // R7
        '{1'b0, 4'd5, 3'd0, 32'h0000_00FF, 3'b010, 32'h0000_0000}, // R8
        '{1'b0, 4'd6, 3'd2, 32'h8000_0004, 3'b001, 32'h0000_0000}, // R8
        '{1'b0, 4'd7, 3'd5, 32'h0000_0000, 3'b100, 32'h0000_0000}, // R8
        '{1'b0, 4'd8, 3'd0, 32'h0000_0000, 3'b000, 32'h0000_0000}, // R8
        '{1'b1, 4'd9, 3'd0, 32'hFFFF_FFFF, 3'b000, 32'h0000_0000}  // R11
    };

    function automatic logic [31:0] mk_instr(input logic [3:0] r, input logic [2:0] o);
        return 32'hEE00_0F10 | ({28'd0, r} << 16) | ({29'd0, o} << 5);
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] pulses();
        return {cache_inv_all, tlb_inv_all, tlb_inv_entry};
    endfunction

    // write during one cycle; returns at the following negedge with pulses visible
    task automatic do_write(input logic m, input logic [3:0] r, input logic [2:0] o,
                            input logic [31:0] d);
        mode_new = m; acc_valid = 1'b1; acc_write = 1'b1;
        instr = mk_instr(r, o); wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic do_read(input logic m, input logic [3:0] r, output logic [31:0] v);
        mode_new = m; acc_valid = 1'b1; acc_write = 1'b0; instr = mk_instr(r, 3'd0);
        #1 v = rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(ctrl_q == 32'h70, "R10 ctrl", ctrl_q, 32'h70);
        check((ttb_q | dom_q | fsr_q | far_q) == 0, "R10 regs", ttb_q | dom_q | fsr_q | far_q, 0);
        check(pulses() == 3'b000, "R10 pulses", {29'd0, pulses()}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(1'b1, 4'd0, v);
        check(v == cfg_id, "R9 id", v, cfg_id);
        do_read(1'b1, 4'd1, v);
        check(v == 32'h70, "R10 ctrl read", v, 32'h70);
        #1 check(rdata == 0, "R9 idle rdata", rdata, 0);

        // R1 vector walk
        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].mode, VECS[i].regn, VECS[i].opc, VECS[i].data);
            check(pulses() == VECS[i].pulse, $sformatf("R1 vec%0d pulse", i),
                  {29'd0, pulses()}, {29'd0, VECS[i].pulse});
            if (VECS[i].pulse == 3'b001)
                check(tlb_inv_addr == VECS[i].data, $sformatf("R7 vec%0d addr", i),
                      tlb_inv_addr, VECS[i].data);
            do_read(VECS[i].mode, VECS[i].regn, v);
            check(v == VECS[i].rd, $sformatf("R9 vec%0d read", i), v, VECS[i].rd);
            check(pulses() == 3'b000, $sformatf("R12 vec%0d drop", i),
                  {29'd0, pulses()}, 0);
        end

        // R8: fault registers unchanged by older-map traffic, hidden in older map
        check(fsr_q == 32'h78, "R8 fsr kept", fsr_q, 32'h78);
        check(far_q == 32'hDEAD_BEEF, "R8 far kept", far_q, 32'hDEAD_BEEF);
        do_read(1'b0, 4'd6, v);
        check(v == 0, "R9 old far hidden", v, 0);
        do_read(1'b1, 4'd6, v);
        check(v == 32'hDEAD_BEEF, "R5 far read", v, 32'hDEAD_BEEF);
        do_read(1'b0, 4'd3, v);
        check(v == 32'hA5A5_5A5A, "R4 old dom read", v, 32'hA5A5_5A5A);

        // R11: undefined write left registers as they were
        check(ctrl_q == 32'h56F7 && ttb_q == 32'hFFFF_C000, "R11 regs", ctrl_q, 32'h56F7);
        // R11: read of cache-op register raises nothing
        do_read(1'b1, 4'd7, v);
        check(pulses() == 3'b000, "R11 read no pulse", {29'd0, pulses()}, 0);

        // R12 back-to-back commands
        mode_new = 1'b1; acc_valid = 1'b1; acc_write = 1'b1;
        instr = mk_instr(4'd7, 3'd0); wdata = 0;
        @(negedge clk);
        check(pulses() == 3'b100, "R12 first", {29'd0, pulses()}, 32'h4);
        instr = mk_instr(4'd8, 3'd1); wdata = 32'h0000_3000;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check(pulses() == 3'b001, "R12 second", {29'd0, pulses()}, 32'h1);
        check(tlb_inv_addr == 32'h3000, "R7 b2b addr", tlb_inv_addr, 32'h3000);
        @(negedge clk);
        check(pulses() == 3'b000, "R12 end", {29'd0, pulses()}, 0);

        // R3 zero pattern through base
        do_write(1'b0, 4'd2, 3'd0, 32'h0000_3FFF);
        check(ttb_q == 0, "R3 low only", ttb_q, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule